// File: doc/BRIEF.md
# Cascadable Nine-Bit Slice ALU with Output Storage

The block is a group of nine one-bit datapath slices. Each slice receives two operand bits, D1 and D2, and has its own configuration word. The word sets the slice either to a two-input Boolean function or to a one-bit full adder. In adder mode the slices link into a carry chain that runs from slice 0 up to slice 8. A separate lookahead unit forms the carry leaving the group directly from the incoming carry and the propagate and generate terms of all nine slices. This keeps the carry path between cascaded groups short.

Each slice result goes to a storage element. The element is either an edge-triggered register or a transparent path. It clocks on one of several clock inputs, chosen per slice, and it has asynchronous preset and clear. Groups chain through `cin_i`/`cout_o` to form wider adders, subtractors, comparators and accumulators. A single group-wide input, `sub_i`, turns addition into subtraction. The group that sits at the bottom of a chain is built with `CHAIN_HEAD=1`.

Top module: `alu9_group`

## Requirements
- R1: A slice in logic mode (configuration bit 3 = 0) drives `f_o` from its function code in bits 2:0: 0 XOR, 1 AND, 2 OR, 3 pass D1, 4 pass D2, 5 AND of both inverted inputs, 6 OR of both inverted inputs, 7 constant 0.
- R2: A slice in arithmetic mode (bit 3 = 1) with `sub_i`=0 drives `f_o` with the sum bit of D1, D2 and the carry from the slice below, and hands the full-adder carry to the slice above.
- R3: With `sub_i`=1 every arithmetic slice uses the inverse of D2. The carry into slice 0 equals `sub_i` when `CHAIN_HEAD`=1 and equals `cin_i` otherwise, so a chain computes D1 minus D2.
- R4: `cout_o` always equals the carry that would ripple out of slice 8.
- R5: A logic-mode slice passes no carry upward, so the slice above receives 0. A group entirely in logic mode has `cout_o`=0.
- R6: In register mode (bit 4 = 0) `q_o` takes the slice result on the rising edge of the selected clock and holds it otherwise.
- R7: Configuration bits 6:5 choose which `clk_i` bit clocks the slice's storage. Edges on the other clock bits leave `q_o` unchanged.
- R8: In transparent mode (bit 4 = 1) `q_o` follows `f_o` without a clock edge.
- R9: `clr_i` forces `q_o` to 0 and `pre_i` forces it to 1, both asynchronously. When both are high, the clear wins.
- R10: Two groups chained through the carry form an 18-bit accumulator whose registered output steps by plus or minus the operand on each clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | NCLK | Independent clock inputs for the storage elements |
| cfg_i | input | SLICES*7 | Per-slice configuration words, slice 0 in the lowest bits |
| d1_i | input | SLICES | First operand bit per slice |
| d2_i | input | SLICES | Second operand bit per slice |
| sub_i | input | 1 | Group-wide subtract select |
| cin_i | input | 1 | Carry from the group below (ignored when CHAIN_HEAD=1) |
| pre_i | input | SLICES | Asynchronous preset per slice |
| clr_i | input | SLICES | Asynchronous clear per slice |
| f_o | output | SLICES | Combinational slice results |
| q_o | output | SLICES | Storage element outputs |
| cout_o | output | 1 | Lookahead carry to the group above |

## Verification
The hardest case to reach is agreement between the lookahead carry and a carry that has rippled through a whole chain of propagating slices and then crossed into a second group. Random operands almost never produce nine propagating bits in a row. The stimulus therefore uses operand pairs that propagate across all bits, such as all-ones plus one and zero minus one, in two cascaded groups. It then runs an 18-bit accumulator long enough for borrows and carries to cross the group boundary many times. A mixed configuration places one logic slice in the middle of an adding chain to show that the carry stops there.

// File: rtl/alu9_pkg.sv
package alu9_pkg;

    localparam int CSEL_W = 2;
    localparam int FN_W   = 3;

    typedef enum logic [FN_W-1:0] {
        FN_XOR    = 3'd0,
        FN_AND    = 3'd1,
        FN_OR     = 3'd2,
        FN_PASS_A = 3'd3,
        FN_PASS_B = 3'd4,
        FN_NOR    = 3'd5,
        FN_NAND   = 3'd6,
        FN_ZERO   = 3'd7
    } fn_e;

    // Configuration word: [2:0] function, [3] arithmetic, [4] transparent, [6:5] clock select
    typedef struct packed {
        logic [CSEL_W-1:0] csel;
        logic              transp;
        logic              arith;
        fn_e               fn;
    } slice_cfg_t;

    localparam int CFG_W = $bits(slice_cfg_t);

    function automatic logic bool_fn(fn_e f, logic a, logic b);
        logic r;
        case (f)
            FN_XOR:    r = a ^ b;
            FN_AND:    r = a & b;
            FN_OR:     r = a | b;
            FN_PASS_A: r = a;
            FN_PASS_B: r = b;
            FN_NOR:    r = ~a & ~b;
            FN_NAND:   r = ~a | ~b;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu9_slice.sv
module alu9_slice
    import alu9_pkg::*;
(
    input  fn_e  fn,
    input  logic arith,
    input  logic a,
    input  logic b,
    input  logic sub,
    input  logic cin,
    output logic f,
    output logic p,
    output logic g
);
    logic b_eff;
    logic half;

    assign b_eff = b ^ sub;
    assign half  = a ^ b_eff;

    always_comb begin
        if (arith) begin
            f = half ^ cin;
            p = half;
            g = a & b_eff;
        end else begin
            f = bool_fn(fn, a, b);
            p = 1'b0;
            g = 1'b0;
        end
    end
endmodule

// File: rtl/alu9_lookahead.sv
module alu9_lookahead #(
    parameter int N = 9
) (
    input  logic [N-1:0] p,
    input  logic [N-1:0] g,
    input  logic         cin,
    output logic         cout
);
    logic grp_p;
    logic grp_g;

    // Flat sum of products: a carry generated in slice i survives if every higher slice propagates.
    always_comb begin
        grp_g = 1'b0;
        for (int i = 0; i < N; i++) begin
            logic pass_up;
            pass_up = 1'b1;
            for (int j = i + 1; j < N; j++) pass_up = pass_up & p[j];
            grp_g = grp_g | (g[i] & pass_up);
        end
        grp_p = &p;
    end

    assign cout = grp_g | (grp_p & cin);
endmodule

// File: rtl/alu9_store.sv
module alu9_store
    import alu9_pkg::*;
#(
    parameter int NCLK = 4
) (
    input  logic [NCLK-1:0]   clk_i,
    input  logic [CSEL_W-1:0] csel,
    input  logic              transp,
    input  logic              pre,
    input  logic              clr,
    input  logic              d,
    output logic              y
);
    logic sclk;
    logic q;

    assign sclk = clk_i[csel];

    always_ff @(posedge sclk or posedge clr or posedge pre) begin
        if (clr)      q <= 1'b0;
        else if (pre) q <= 1'b1;
        else          q <= d;
    end

    always_comb begin
        if (clr)         y = 1'b0;
        else if (pre)    y = 1'b1;
        else if (transp) y = d;
        else             y = q;
    end

    a_r8_transparent_follows: assert property (@(posedge sclk) disable iff (clr | pre)
        transp |-> (y == d));

    a_r9_clear_beats_preset: assert property (@(posedge sclk) disable iff (!pre)
        clr |-> (y == 1'b0));
endmodule

// File: rtl/alu9_group.sv
module alu9_group
    import alu9_pkg::*;
#(
    parameter int SLICES     = 9,
    parameter int NCLK       = 4,
    parameter bit CHAIN_HEAD = 1'b1
) (
    input  logic [NCLK-1:0]         clk_i,
    input  logic [SLICES*CFG_W-1:0] cfg_i,
    input  logic [SLICES-1:0]       d1_i,
    input  logic [SLICES-1:0]       d2_i,
    input  logic                    sub_i,
    input  logic                    cin_i,
    input  logic [SLICES-1:0]       pre_i,
    input  logic [SLICES-1:0]       clr_i,
    output logic [SLICES-1:0]       f_o,
    output logic [SLICES-1:0]       q_o,
    output logic                    cout_o
);
    localparam int CLK_SPAN = 1 << CSEL_W;

    slice_cfg_t          cfg   [SLICES];
    logic [SLICES:0]     carry;
    logic [SLICES-1:0]   p_vec;
    logic [SLICES-1:0]   g_vec;

    initial begin
        if (NCLK > CLK_SPAN) $error("NCLK exceeds clock select range");
    end

    generate
        if (CHAIN_HEAD) begin : g_head
            assign carry[0] = sub_i;
        end else begin : g_link
            assign carry[0] = cin_i;
        end
    endgenerate

    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        assign cfg[k] = slice_cfg_t'(cfg_i[k*CFG_W +: CFG_W]);

        alu9_slice u_alu (
            .fn    (cfg[k].fn),
            .arith (cfg[k].arith),
            .a     (d1_i[k]),
            .b     (d2_i[k]),
            .sub   (sub_i),
            .cin   (carry[k]),
            .f     (f_o[k]),
            .p     (p_vec[k]),
            .g     (g_vec[k])
        );

        assign carry[k+1] = g_vec[k] | (p_vec[k] & carry[k]);

        alu9_store #(.NCLK(NCLK)) u_st (
            .clk_i  (clk_i),
            .csel   (cfg[k].csel),
            .transp (cfg[k].transp),
            .pre    (pre_i[k]),
            .clr    (clr_i[k]),
            .d      (f_o[k]),
            .y      (q_o[k])
        );

        a_r5_logic_kills_carry: assert property (@(posedge clk_i[0]) disable iff (|clr_i)
            !cfg[k].arith |-> (carry[k+1] == 1'b0));
    end

    alu9_lookahead #(.N(SLICES)) u_cla (
        .p    (p_vec),
        .g    (g_vec),
        .cin  (carry[0]),
        .cout (cout_o)
    );

    a_r4_lookahead_match: assert property (@(posedge clk_i[0]) disable iff (|clr_i)
        cout_o == carry[SLICES]);
endmodule

// File: tb/sim_alu9_group.sv
module sim_alu9_group;
    import alu9_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int S  = 9;
    localparam int W  = 2 * S;
    localparam int NT = 16;

    // entry: {fn, d1, d2, expected}
    localparam logic [29:0] VEC [NT] = '{
        {3'd0, 9'h0AA, 9'h0CC, 9'h066},
        {3'd1, 9'h0AA, 9'h0CC, 9'h088},
        {3'd2, 9'h0AA, 9'h0CC, 9'h0EE},
        {3'd3, 9'h0AA, 9'h0CC, 9'h0AA},
        {3'd4, 9'h0AA, 9'h0CC, 9'h0CC},
        {3'd5, 9'h0AA, 9'h0CC, 9'h111},
        {3'd6, 9'h0AA, 9'h0CC, 9'h177},
        {3'd7, 9'h0AA, 9'h0CC, 9'h000},
        {3'd0, 9'h1FF, 9'h000, 9'h1FF},
        {3'd1, 9'h1FF, 9'h000, 9'h000},
        {3'd2, 9'h1FF, 9'h000, 9'h1FF},
        {3'd3, 9'h1FF, 9'h000, 9'h1FF},
        {3'd4, 9'h1FF, 9'h000, 9'h000},
        {3'd5, 9'h1FF, 9'h000, 9'h000},
        {3'd6, 9'h1FF, 9'h000, 9'h1FF},
        {3'd7, 9'h1FF, 9'h000, 9'h000}
    };

    logic clk0 = 1'b0;
    logic clk1 = 1'b0;
    logic [3:0] clks;
    logic [S*CFG_W-1:0] cfg;
    logic [W-1:0] d1, d2, pre, clr, f, q;
    logic sub;
    logic co_lo, co_hi;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    assign clks = {2'b00, clk1, clk0};
    always #(CLK_PERIOD/2) clk0 = ~clk0;

    alu9_group #(.SLICES(S), .NCLK(4), .CHAIN_HEAD(1'b1)) u0 (
        .clk_i(clks), .cfg_i(cfg), .d1_i(d1[S-1:0]), .d2_i(d2[S-1:0]), .sub_i(sub),
        .cin_i(1'b0), .pre_i(pre[S-1:0]), .clr_i(clr[S-1:0]),
        .f_o(f[S-1:0]), .q_o(q[S-1:0]), .cout_o(co_lo));

    alu9_group #(.SLICES(S), .NCLK(4), .CHAIN_HEAD(1'b0)) u1 (
        .clk_i(clks), .cfg_i(cfg), .d1_i(d1[W-1:S]), .d2_i(d2[W-1:S]), .sub_i(sub),
        .cin_i(co_lo), .pre_i(pre[W-1:S]), .clr_i(clr[W-1:S]),
        .f_o(f[W-1:S]), .q_o(q[W-1:S]), .cout_o(co_hi));

    function automatic logic [S*CFG_W-1:0] all_cfg(logic [2:0] fn, logic ar, logic tr, logic [1:0] cs);
        logic [S*CFG_W-1:0] v;
        for (int k = 0; k < S; k++) v[k*CFG_W +: CFG_W] = {cs, tr, ar, fn};
        return v;
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] acc;
        cfg = all_cfg(3'd0, 1'b1, 1'b0, 2'd0);
        d1 = '0; d2 = '0; sub = 1'b0; pre = '0; clr = '1;
        @(negedge clk0);
        check("R9 reset state", q, '0);
        clr = '0;

        // R1 R5 R6: table of logic functions
        for (int i = 0; i < NT; i++) begin
            @(negedge clk0);
            cfg = all_cfg(VEC[i][29:27], 1'b0, 1'b0, 2'd0);
            d1 = {2{VEC[i][26:18]}};
            d2 = {2{VEC[i][17:9]}};
            #1;
            check("R1 logic function", {9'd0, f[S-1:0]}, {9'd0, VEC[i][8:0]});
            check("R5 logic group carry", {16'd0, co_hi, co_lo}, '0);
            @(negedge clk0);
            check("R6 register capture", {9'd0, q[S-1:0]}, {9'd0, VEC[i][8:0]});
        end

        // R5: logic slice 4 in the middle of an adding chain
        @(negedge clk0);
        cfg = all_cfg(3'd0, 1'b1, 1'b0, 2'd0);
        cfg[4*CFG_W + 3] = 1'b0;
        d1 = {9'd0, 9'h1FF}; d2 = {9'd0, 9'h001}; sub = 1'b0;
        #1;
        check("R5 carry stopped by logic slice", {8'd0, co_lo, f[S-1:0]}, {8'd0, 1'b0, 9'h1F0});

        // R2 R4: full propagate across both groups
        cfg = all_cfg(3'd0, 1'b1, 1'b0, 2'd0);
        d1 = {9'h000, 9'h1FF}; d2 = {9'h000, 9'h001};
        #1;
        check("R2 add sum", f, 18'h00200);
        check("R4 lookahead carry", {16'd0, co_hi, co_lo}, 18'd1);
        // R3: 0 - 1 borrows through all 18 bits
        d1 = '0; d2 = 18'd1; sub = 1'b1;
        #1;
        check("R3 subtract", f, 18'h3FFFF);
        check("R4 subtract carries", {16'd0, co_hi, co_lo}, 18'd0);

        // R2 R3 R4: random operands against a 19-bit model
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a, b, bm;
            logic [W:0] full;
            logic [S:0] low;
            a = W'($urandom); b = W'($urandom);
            if (i % 8 == 0) b = ~a;
            sub = 1'(i % 2);
            bm = sub ? ~b : b;
            full = {1'b0, a} + {1'b0, bm} + (W+1)'(sub);
            low  = {1'b0, a[S-1:0]} + {1'b0, bm[S-1:0]} + (S+1)'(sub);
            d1 = a; d2 = b;
            #1;
            check(sub ? "R3 random subtract" : "R2 random add", f, full[W-1:0]);
            check("R4 lookahead vs model carries", {16'd0, co_hi, co_lo}, {16'd0, full[W], low[S]});
        end

        // R10: cascaded accumulator
        @(negedge clk0);
        clr = '1; #1; clr = '0;
        acc = '0;
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] x;
            x = W'($urandom);
            sub = 1'($urandom);
            d1 = q; d2 = x;
            acc = sub ? acc - x : acc + x;
            @(negedge clk0);
            check("R10 accumulator", q, acc);
        end

        // R8: transparent mode, checked between clock edges
        cfg = all_cfg(3'd0, 1'b1, 1'b1, 2'd0);
        d1 = 18'h12345; d2 = 18'h00F0F; sub = 1'b0;
        #1;
        check("R8 transparent follows", q, 18'h13254);

        // R7: storage on clk_i[1] ignores clk_i[0]
        cfg = all_cfg(3'd0, 1'b1, 1'b0, 2'd1);
        clr = '1; #1; clr = '0;
        d1 = 18'h00055; d2 = 18'h00000;
        @(negedge clk0);
        @(negedge clk0);
        check("R7 other clock ignored", q, '0);
        #1 clk1 = 1'b1; #1 clk1 = 1'b0; #1;
        check("R7 selected clock captures", q, 18'h00055);

        // R9: preset, clear, and both together
        pre = '1; #1;
        check("R9 preset", q, 18'h3FFFF);
        clr = '1; #1;
        check("R9 clear wins over preset", q, '0);
        pre = '0; clr = '0; #1;
        check("R9 held after release", q, '0);

        @(negedge clk0);
        finish_run();
    end
endmodule